// File: doc/BRIEF.md
# SPI Chip-Select Delay Timer

This block measures out the three guard intervals an SPI master inserts around its serial clock: the settling time from chip-select assertion to the first clock edge, the hold time from the last clock edge to chip-select release, and the idle gap between two frames. The sequencer of the master pulses `start_i` and names the interval it wants on `kind_i`. The timer then counts system clock cycles and returns a single-cycle `done_o` when the interval is over.

Each interval is encoded as an odd prescaler code and a power-of-two scaler code. Both codes are taken from a shared 32-bit attribute word that the master already holds for the current slave. The length in cycles is the product of the two factors, so one 6-bit pair can describe intervals from 2 to 458752 cycles. The codes are captured at the moment a start is accepted. While `busy_o` is high, the attribute word may change without affecting the interval in progress.

Top module: `csd_delay_timer`

## Requirements
- R1: Prescaler code p (0..3) selects a factor of 2p+1, giving 1, 3, 5 or 7.
- R2: Scaler code s (0..15) selects a factor of 2^(s+1), giving 2 up to 65536.
- R3: A start accepted at clock edge E gives `done_o` high in the cycle after edge E+N, where N is the prescaler factor times the scaler factor. `busy_o` is high from the cycle after E until `done_o` rises.
- R4: `kind_i` picks the fields of `attr_i` as follows. Code 0 (select-to-clock) uses prescaler bits 23:22 and scaler bits 15:12. Code 1 (clock-to-release) uses bits 21:20 and 11:8. Code 2 (inter-frame gap) uses bits 19:18 and 7:4. All other bits are ignored.
- R5: `done_o` lasts exactly one cycle, and `busy_o` is low while it is high.
- R6: A start pulse that arrives while `busy_o` is high is ignored, and the running count keeps its length.
- R7: Every code pair, up to 7 × 65536 cycles, counts to its full length without wrapping.
- R8: A start with `kind_i` = 3 is ignored: neither `busy_o` nor `done_o` rises.
- R9: After synchronous reset, `busy_o` and `done_o` are low.
- R10: Changes to `attr_i` after a start has been accepted do not alter that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an interval |
| kind_i | input | 2 | Interval select: 0 select-to-clock, 1 clock-to-release, 2 inter-frame gap |
| attr_i | input | 32 | Attribute word holding the prescaler and scaler codes |
| busy_o | output | 1 | An interval is being counted |
| done_o | output | 1 | One-cycle pulse at the end of the interval |

## Verification
The hardest condition to create is a count at the largest lengths, because a counter that is too narrow only shows its fault there. One full-range scaler run of 65536 cycles and one of 57344 cycles with the top prescaler are timed cycle by cycle. Field selection is stressed by filling the unselected fields with all-ones in some runs and all-zeros in others, so reading the wrong field changes the measured length. Start pulses and attribute changes are injected in the middle of counts to show that they are ignored.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int PRE_W    = 2;
  localparam int SC_W     = 4;
  localparam int FACTOR_W = 3;
  localparam int KIND_W   = 2;
  localparam int KINDS    = 3;

  typedef enum logic [KIND_W-1:0] {
    DLY_LEAD  = 2'd0,
    DLY_TRAIL = 2'd1,
    DLY_GAP   = 2'd2,
    DLY_NONE  = 2'd3
  } dly_kind_e;

  // odd prescaler: 1, 3, 5, 7
  function automatic logic [FACTOR_W-1:0] pre_factor(input logic [PRE_W-1:0] code);
    logic [FACTOR_W-1:0] f;
    case (code)
      2'd0:    f = 3'd1;
      2'd1:    f = 3'd3;
      2'd2:    f = 3'd5;
      default: f = 3'd7;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/csd_field_pick.sv
module csd_field_pick
  import csd_pkg::*;
#(
  parameter int ATTR_W  = 32,
  parameter int PRE_TOP = 23,
  parameter int SC_TOP  = 15
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [SC_W-1:0]   sc_o,
  output logic              valid_o
);

  logic [PRE_W-1:0] pre_arr [KINDS];
  logic [SC_W-1:0]  sc_arr  [KINDS];

  // fields are packed downward from the top positions, one slot per kind
  for (genvar g = 0; g < KINDS; g++) begin : g_kind
    localparam int PRE_LO = PRE_TOP - PRE_W * (g + 1) + 1;
    localparam int SC_LO  = SC_TOP - SC_W * (g + 1) + 1;
    assign pre_arr[g] = attr_i[PRE_LO +: PRE_W];
    assign sc_arr[g]  = attr_i[SC_LO +: SC_W];
  end

  always_comb begin
    valid_o = 1'b0;
    pre_o   = '0;
    sc_o    = '0;
    for (int i = 0; i < KINDS; i++) begin
      if (32'(kind_i) == i) begin
        valid_o = 1'b1;
        pre_o   = pre_arr[i];
        sc_o    = sc_arr[i];
      end
    end
  end

  logic unused_attr;
  assign unused_attr = ^attr_i;

endmodule

// File: rtl/csd_len_calc.sv
module csd_len_calc
  import csd_pkg::*;
#(
  parameter int CNT_W = FACTOR_W + (1 << SC_W)
) (
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SC_W-1:0]  sc_i,
  output logic [CNT_W-1:0] len_m1_o
);

  localparam int SHIFT_W = SC_W + 1;

  logic [FACTOR_W-1:0] fac;
  logic [SHIFT_W-1:0]  shamt;
  logic [CNT_W-1:0]    len;

  always_comb begin
    fac      = pre_factor(pre_i);
    shamt    = {1'b0, sc_i} + SHIFT_W'(1);
    len      = {{(CNT_W-FACTOR_W){1'b0}}, fac} << shamt;
    len_m1_o = len - CNT_W'(1);
  end

endmodule

// File: rtl/csd_down_counter.sv
module csd_down_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else if (load_i) begin
        cnt_q  <= val_i;
        busy_o <= 1'b1;
      end
    end
  end

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_end_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/csd_delay_timer.sv
module csd_delay_timer
  import csd_pkg::*;
#(
  parameter int ATTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ATTR_W-1:0] attr_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CNT_W = FACTOR_W + (1 << SC_W);
  localparam logic [CNT_W:0] MAX_LEN = (CNT_W+1)'(7) << (1 << SC_W);

  logic [PRE_W-1:0] pre_code;
  logic [SC_W-1:0]  sc_code;
  logic             kind_ok;
  logic [CNT_W-1:0] len_m1;
  logic             accept;

  csd_field_pick #(.ATTR_W(ATTR_W)) u_pick (
    .attr_i  (attr_i),
    .kind_i  (kind_i),
    .pre_o   (pre_code),
    .sc_o    (sc_code),
    .valid_o (kind_ok)
  );

  csd_len_calc #(.CNT_W(CNT_W)) u_len (
    .pre_i    (pre_code),
    .sc_i     (sc_code),
    .len_m1_o (len_m1)
  );

  assign accept = start_i && kind_ok && !busy_o;

  csd_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .val_i  (len_m1),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    accept |-> ({1'b0, len_m1} < MAX_LEN));

  p_bad_kind_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && kind_i == DLY_NONE && !busy_o) |=> !busy_o);

  p_busy_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/csd_delay_timer_test.sv
module csd_delay_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [31:0] attr_i = 32'h0;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  csd_delay_timer uut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .kind_i  (kind_i),
    .attr_i  (attr_i),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_attr(input int kind, input int pre, input int sc,
                                          input logic [31:0] fill);
    logic [31:0] a = fill;
    a[23 - 2*kind -: 2] = pre[1:0];
    a[15 - 4*kind -: 4] = sc[3:0];
    return a;
  endfunction

  // mode 0: plain, 1: extra start with new attr mid-count, 2: attr change only
  task automatic run(input int kind, input int pre, input int sc,
                     input logic [31:0] fill, input int mode);
    int n = (2*pre + 1) * (1 << (sc + 1));
    int k = 0;
    @(negedge clk);
    kind_i  = kind[1:0];
    attr_i  = mk_attr(kind, pre, sc, fill);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R3 busy after start", int'(busy_o), 1);
    while (!done_o && k < n + 4) begin
      if (k == 1 && mode != 0) begin
        attr_i = mk_attr(kind, 0, 0, ~fill);
        if (mode == 1) begin
          start_i = 1'b1;
          kind_i  = 2'd0;
        end
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    if (mode == 1)      chk(k == n, "R6 length with start while busy", k, n);
    else if (mode == 2) chk(k == n, "R10 length with attr change", k, n);
    else                chk(k == n, "R1 R2 R3 R4 interval length", k, n);
    @(negedge clk);
    chk(!done_o && !busy_o, "R5 single done pulse", int'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R9 reset state", int'(busy_o | done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o, "R9 idle after reset", int'(busy_o | done_o), 0);

    // R8: unused kind code
    kind_i  = 2'd3;
    attr_i  = 32'hFFFF_FFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(!busy_o && !done_o, "R8 kind 3 ignored", int'(busy_o | done_o), 0);
      @(negedge clk);
    end

    // sweep every kind, prescaler and low scaler codes; alternate fill
    for (int kd = 0; kd < 3; kd++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 7; s++)
          run(kd, p, s, ((p + s) % 2 == 1) ? 32'hFFFF_FFFF : 32'h0, 0);

    // R6 / R10: disturbances mid-count
    run(0, 1, 2, 32'h0, 1);
    run(1, 3, 3, 32'hFFFF_FFFF, 1);
    run(2, 2, 4, 32'h0, 2);
    run(1, 0, 5, 32'hFFFF_FFFF, 2);

    // R7: long counts
    run(2, 0, 15, 32'h0, 0);
    run(0, 3, 12, 32'hFFFF_FFFF, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule